// File: doc/BRIEF.md
# PCI Configuration Header Register File

This block holds the writable and hard-wired fields of a type-0 configuration header for a single-function device. It covers the cache line size byte, the latency timer, the header type and three base address registers (BARs). Two BARs claim memory space and one claims I/O space. Configuration requests arrive as a dword index, four byte enables and 32-bit write data. A read is registered, so its data is valid in the cycle after the request.

The BARs hold only the address bits above their region size. The space indicator, type and prefetch bits are fixed, and so are the bits below the region size. Software can therefore size a region by writing all ones and reading the value back. The cache line size byte accepts only two encodings. The latency timer value is also driven out to the bus master logic.

Top module: `cfgHdrRegs`

## Requirements
- R1: After reset, dword 3 reads 00000000h, dwords 4 and 5 read 00000000h, dword 6 reads 00000001h, and `latencyTimer` is 00h.
- R2: A read issued with `cfgRdEn` in one cycle shows its data on `rdData` in the next cycle. `rdData` is 00000000h in any cycle not preceded by a read. Any dword index outside 3 to 6 reads 00000000h.
- R3: Writing dword 3 with byte lane 0 enabled and byte value 08h makes bits 7:0 read 08h. A byte value of 10h makes them read 10h.
- R4: Writing any other byte value to dword 3 lane 0 clears bits 7:0 to 00h. A write with lane 0 disabled leaves them unchanged.
- R5: Dword 3 bits 15:8 are the read/write latency timer, written through lane 1. `latencyTimer` shows the new value in the cycle after the write.
- R6: Dword 3 bits 31:16 always read 0000h, which includes header type 00h in bits 23:16. Writes to lanes 2 and 3 have no effect.
- R7: The memory BARs at dwords 4 and 5 read 0 in bits 11:0: space bit 0 = 0, type bits 2:1 = 00, prefetch bit 3 = 0. Bits 31:12 are writable, so writing FFFFFFFFh reads back FFFFF000h.
- R8: The I/O BAR at dword 6 reads 1 in bit 0 and 0 in bits 4:1. Bits 31:5 are writable, so writing FFFFFFFFh reads back FFFFFFE1h.
- R9: Byte enable bit n (n = 0 to 3) gates bits 8n+7:8n of a BAR write. Disabled lanes keep their old value.
- R10: Writes to dword indices outside 3 to 6 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write request |
| cfgRdEn | input | 1 | Configuration read request |
| cfgIdx | input | IDX_W (6) | Dword index into the header |
| cfgByteEn | input | 4 | Byte lane enables for writes |
| cfgWrData | input | 32 | Write data |
| rdData | output | 32 | Read data, valid the cycle after `cfgRdEn` |
| latencyTimer | output | 8 | Current latency timer value for the master logic |

## Verification
A corrupted BAR store or a missing attribute bit shows up on `rdData` one cycle after the next read of that dword. For example, the I/O BAR might read with bit 0 clear, or a memory BAR might show set bits below bit 12. A wrong cache line size filter shows up as a byte other than 00h, 08h or 10h on the first read after the write. A lane-gating fault shows up only in the disabled lanes of a partial write. The latency timer is also visible directly on `latencyTimer` one cycle after its write.

// File: rtl/cfgHdrPkg.sv
package cfgHdrPkg;
  // Fixed by the type-0 header layout
  localparam int MAX_BARS     = 6;
  localparam int BAR_SEL_W    = 3;
  localparam int MISC_DW_IDX  = 3;
  localparam int BAR_BASE_IDX = 4;

  typedef struct packed {
    logic                 miscWr;
    logic                 miscRd;
    logic                 barWr;
    logic                 barRd;
    logic [BAR_SEL_W-1:0] barSel;
    logic [3:0]           byteEn;
  } cfgStrobe_t;

  function automatic logic [31:0] sizeMask(input int sizeLog2);
    return ~((32'd1 << sizeLog2) - 32'd1);
  endfunction
endpackage

// File: rtl/cfgHdrCtrl.sv
module cfgHdrCtrl
  import cfgHdrPkg::*;
#(
  parameter int IDX_W    = 6,
  parameter int NUM_BARS = 3
) (
  input  logic             cfgWrEn,
  input  logic             cfgRdEn,
  input  logic [IDX_W-1:0] cfgIdx,
  input  logic [3:0]       cfgByteEn,
  output cfgStrobe_t       strb
);
  localparam logic [IDX_W-1:0] MISC_IDX = IDX_W'(MISC_DW_IDX);
  localparam logic [IDX_W-1:0] BAR_LO   = IDX_W'(BAR_BASE_IDX);
  localparam logic [IDX_W-1:0] BAR_HI   = IDX_W'(BAR_BASE_IDX + NUM_BARS);

  logic             isMisc;
  logic             isBar;
  logic [IDX_W-1:0] barOff;

  always_comb begin
    isMisc = (cfgIdx == MISC_IDX);
    isBar  = (cfgIdx >= BAR_LO) && (cfgIdx < BAR_HI);
    barOff = cfgIdx - BAR_LO;

    strb.miscWr = cfgWrEn && isMisc;
    strb.miscRd = cfgRdEn && isMisc;
    strb.barWr  = cfgWrEn && isBar;
    strb.barRd  = cfgRdEn && isBar;
    strb.barSel = barOff[BAR_SEL_W-1:0];
    strb.byteEn = cfgByteEn;
  end
endmodule

// File: rtl/cfgHdrDatapath.sv
module cfgHdrDatapath
  import cfgHdrPkg::*;
#(
  parameter int NUM_MEM_BARS  = 2,
  parameter int MEM_SIZE_LOG2 = 12,
  parameter int IO_SIZE_LOG2  = 5
) (
  input  logic        clk,
  input  logic        rstN,
  input  cfgStrobe_t  strb,
  input  logic [31:0] cfgWrData,
  output logic [31:0] rdData,
  output logic [7:0]  latencyTimer
);
  localparam int          NUM_BARS = NUM_MEM_BARS + 1;
  localparam logic [31:0] MEM_MASK = sizeMask(MEM_SIZE_LOG2);
  localparam logic [31:0] IO_MASK  = sizeMask(IO_SIZE_LOG2);
  localparam logic [7:0]  CLS_A    = 8'h08;
  localparam logic [7:0]  CLS_B    = 8'h10;

  logic [7:0]  clsReg;
  logic [7:0]  latReg;
  logic [31:0] laneMask;
  logic [31:0] barView [NUM_BARS];
  logic [31:0] rdNext;

  always_comb begin
    for (int b = 0; b < 4; b++) laneMask[b*8 +: 8] = {8{strb.byteEn[b]}};
  end

  // Cache line size filter and latency timer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      clsReg <= '0;
      latReg <= '0;
    end else if (strb.miscWr) begin
      if (strb.byteEn[0]) begin
        if (cfgWrData[7:0] == CLS_A)      clsReg <= CLS_A;
        else if (cfgWrData[7:0] == CLS_B) clsReg <= CLS_B;
        else                              clsReg <= '0;
      end
      if (strb.byteEn[1]) latReg <= cfgWrData[15:8];
    end
  end

  // BAR storage: memory BARs first, the I/O BAR last
  for (genvar g = 0; g < NUM_BARS; g++) begin : gBar
    localparam bit          IS_IO  = (g == NUM_BARS - 1);
    localparam logic [31:0] W_MASK = IS_IO ? IO_MASK : MEM_MASK;
    localparam logic [31:0] ATTR   = IS_IO ? 32'h0000_0001 : 32'h0000_0000;
    logic [31:0] barStore;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        barStore <= '0;
      end else if (strb.barWr && (strb.barSel == BAR_SEL_W'(g))) begin
        barStore <= (barStore & ~laneMask) | (cfgWrData & laneMask & W_MASK);
      end
    end

    assign barView[g] = barStore | ATTR;
  end

  always_comb begin
    rdNext = '0;
    if (strb.miscRd) rdNext = {16'h0000, latReg, clsReg};
    if (strb.barRd) begin
      for (int i = 0; i < NUM_BARS; i++) begin
        if (strb.barSel == BAR_SEL_W'(i)) rdNext = barView[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else       rdData <= rdNext;
  end

  assign latencyTimer = latReg;
endmodule

// File: rtl/cfgHdrRegs.sv
module cfgHdrRegs
  import cfgHdrPkg::*;
#(
  parameter int IDX_W         = 6,
  parameter int NUM_MEM_BARS  = 2,
  parameter int MEM_SIZE_LOG2 = 12,
  parameter int IO_SIZE_LOG2  = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic             cfgRdEn,
  input  logic [IDX_W-1:0] cfgIdx,
  input  logic [3:0]       cfgByteEn,
  input  logic [31:0]      cfgWrData,
  output logic [31:0]      rdData,
  output logic [7:0]       latencyTimer
);
  localparam int NUM_BARS = NUM_MEM_BARS + 1;

  cfgStrobe_t strb;

  cfgHdrCtrl #(
    .IDX_W   (IDX_W),
    .NUM_BARS(NUM_BARS)
  ) ctrl_i (
    .cfgWrEn  (cfgWrEn),
    .cfgRdEn  (cfgRdEn),
    .cfgIdx   (cfgIdx),
    .cfgByteEn(cfgByteEn),
    .strb     (strb)
  );

  cfgHdrDatapath #(
    .NUM_MEM_BARS (NUM_MEM_BARS),
    .MEM_SIZE_LOG2(MEM_SIZE_LOG2),
    .IO_SIZE_LOG2 (IO_SIZE_LOG2)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .cfgWrData   (cfgWrData),
    .rdData      (rdData),
    .latencyTimer(latencyTimer)
  );
endmodule

// File: rtl/cfgHdrChk.sv
module cfgHdrChk #(
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             cfgWrEn,
  input logic             cfgRdEn,
  input logic [IDX_W-1:0] cfgIdx,
  input logic [3:0]       cfgByteEn,
  input logic [31:0]      cfgWrData,
  input logic [31:0]      rdData,
  input logic [7:0]       latencyTimer
);
  logic rdMisc, rdMem, rdIo;
  assign rdMisc = cfgRdEn && (cfgIdx == IDX_W'(3));
  assign rdMem  = cfgRdEn && ((cfgIdx == IDX_W'(4)) || (cfgIdx == IDX_W'(5)));
  assign rdIo   = cfgRdEn && (cfgIdx == IDX_W'(6));

  // R2: no read request, no data
  p_rd_idle_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    !$past(cfgRdEn) |-> (rdData == 32'h0));

  // R4: cache line size only ever shows a legal encoding
  p_cls_legal_r4: assert property (@(posedge clk) disable iff (!rstN)
    $past(rdMisc) |-> (rdData[7:0] == 8'h00 || rdData[7:0] == 8'h08 || rdData[7:0] == 8'h10));

  // R5: the latency timer moves only after a write
  p_lat_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !$past(cfgWrEn) |-> $stable(latencyTimer));

  // R6: the upper half of dword 3 reads zero
  p_hdr_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    $past(rdMisc) |-> (rdData[31:16] == 16'h0));

  // R7: memory BAR low bits are fixed at zero
  p_membar_attr_r7: assert property (@(posedge clk) disable iff (!rstN)
    $past(rdMem) |-> (rdData[11:0] == 12'h0));

  // R8: I/O BAR low bits read 00001b
  p_iobar_attr_r8: assert property (@(posedge clk) disable iff (!rstN)
    $past(rdIo) |-> (rdData[4:0] == 5'b00001));
endmodule

bind cfgHdrRegs cfgHdrChk #(.IDX_W(IDX_W)) chk_i (.*);

// File: tb/cfgHdrRegs_tb.sv
module cfgHdrRegs_tb_top;
  localparam int IDX_W = 6;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             cfgWrEn = 1'b0;
  logic             cfgRdEn = 1'b0;
  logic [IDX_W-1:0] cfgIdx = '0;
  logic [3:0]       cfgByteEn = '0;
  logic [31:0]      cfgWrData = '0;
  logic [31:0]      rdData;
  logic [7:0]       latencyTimer;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  done    = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  cfgHdrRegs #(.IDX_W(IDX_W)) dut_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgRdEn(cfgRdEn),
    .cfgIdx(cfgIdx), .cfgByteEn(cfgByteEn), .cfgWrData(cfgWrData),
    .rdData(rdData), .latencyTimer(latencyTimer)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input int idx, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgIdx = IDX_W'(idx); cfgByteEn = be; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0; cfgByteEn = '0; cfgWrData = '0;
  endtask

  task automatic doRead(input int idx, output logic [31:0] d);
    @(negedge clk);
    cfgRdEn = 1'b1; cfgIdx = IDX_W'(idx);
    @(negedge clk);
    cfgRdEn = 1'b0;
    d = rdData;
  endtask

  task automatic tReset();
    logic [31:0] v;
    check("R1 latencyTimer", {24'h0, latencyTimer}, 32'h0);
    doRead(3, v); check("R1 dword3", v, 32'h0);
    doRead(4, v); check("R1 bar0", v, 32'h0);
    doRead(5, v); check("R1 bar1", v, 32'h0);
    doRead(6, v); check("R1 bar2 io", v, 32'h1);
  endtask

  task automatic tReadTiming();
    logic [31:0] v;
    doRead(6, v);
    @(negedge clk);
    check("R2 idle after read", rdData, 32'h0);
    doRead(2, v);  check("R2 unmapped idx2", v, 32'h0);
    doRead(40, v); check("R2 unmapped idx40", v, 32'h0);
  endtask

  task automatic tLatency();
    logic [31:0] v;
    doWrite(3, 4'b0010, 32'h0000_5A00);
    check("R5 latencyTimer out", {24'h0, latencyTimer}, 32'h5A);
    doRead(3, v); check("R5 dword3", v, 32'h0000_5A00);
  endtask

  task automatic tCacheLine();
    logic [31:0] v;
    doWrite(3, 4'b0001, 32'h08); doRead(3, v); check("R3 cls 08", {24'h0, v[7:0]}, 32'h08);
    doWrite(3, 4'b0001, 32'h10); doRead(3, v); check("R3 cls 10", {24'h0, v[7:0]}, 32'h10);
    doWrite(3, 4'b0001, 32'h18); doRead(3, v); check("R4 cls 18 clears", {24'h0, v[7:0]}, 32'h00);
    doWrite(3, 4'b0001, 32'h08);
    doWrite(3, 4'b0001, 32'h04); doRead(3, v); check("R4 cls 04 clears", {24'h0, v[7:0]}, 32'h00);
    doWrite(3, 4'b0001, 32'h08);
    doWrite(3, 4'b0010, 32'h0000_5A33); doRead(3, v); check("R4 lane0 off keeps", v, 32'h0000_5A08);
  endtask

  task automatic tHeader();
    logic [31:0] v;
    doWrite(3, 4'b1100, 32'hFFFF_FFFF); doRead(3, v);
    check("R6 upper half zero", v, 32'h0000_5A08);
  endtask

  task automatic tMemBar();
    logic [31:0] v;
    doWrite(4, 4'b1111, 32'hFFFF_FFFF); doRead(4, v); check("R7 bar0 size", v, 32'hFFFF_F000);
    doRead(5, v); check("R7 bar1 untouched", v, 32'h0);
    doWrite(4, 4'b1111, 32'h1234_5FFF); doRead(4, v); check("R7 bar0 base", v, 32'h1234_5000);
  endtask

  task automatic tIoBar();
    logic [31:0] v;
    doWrite(6, 4'b1111, 32'hFFFF_FFFF); doRead(6, v); check("R8 io size", v, 32'hFFFF_FFE1);
    doWrite(6, 4'b1111, 32'h0000_C01E); doRead(6, v); check("R8 io base", v, 32'h0000_C001);
  endtask

  task automatic tByteEn();
    logic [31:0] v;
    doWrite(5, 4'b0100, 32'hFFFF_FFFF); doRead(5, v); check("R9 bar1 lane2", v, 32'h00FF_0000);
    doWrite(5, 4'b0010, 32'hFFFF_AB00); doRead(5, v); check("R9 bar1 lane1", v, 32'h00FF_A000);
    doWrite(6, 4'b1111, 32'hFFFF_FFFF);
    doWrite(6, 4'b0001, 32'h0);         doRead(6, v); check("R9 io lane0", v, 32'hFFFF_FF01);
  endtask

  task automatic tUnmapped();
    logic [31:0] v;
    doWrite(7, 4'b1111, 32'hFFFF_FFFF);
    doWrite(2, 4'b1111, 32'hFFFF_FFFF);
    doRead(7, v); check("R10 idx7 reads zero", v, 32'h0);
    doRead(3, v); check("R10 dword3 kept", v, 32'h0000_5A08);
    doRead(4, v); check("R10 bar0 kept", v, 32'h1234_5000);
    doRead(5, v); check("R10 bar1 kept", v, 32'h00FF_A000);
    doRead(6, v); check("R10 bar2 kept", v, 32'hFFFF_FF01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tReadTiming();
    tLatency();
    tCacheLine();
    tHeader();
    tMemBar();
    tIoBar();
    tByteEn();
    tUnmapped();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule